// File: doc/BRIEF.md
# SPI EEPROM Slave Command Engine

This block is the slave side of a small serial EEPROM on an SPI bus. It works in clock mode 0 and in mode 3. It takes a command byte, an optional address byte and any data bytes from the serial input. It keeps three pieces of state: a write-enable flag, a two-bit protect level and a page buffer. When chip select goes high after a write, it commits the buffered page to a register-array memory. A timed busy window follows, and only a status read gets through while it runs.

The serial pins are sampled by the system clock, so the serial clock, chip select and serial input must be synchronous to that clock. Each serial clock phase must last at least two system clocks. The serial output comes with an output-enable signal, which stands in for a tri-state pin. The parameters set the address width (7 to 9 bits), the page size and the length of the write cycle in clocks.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset, the status byte reads 0x00, the output enable is low and every memory byte reads 0xFF.
- R2: Status read (0x05) returns, once per byte for as long as chip select stays low, a byte with these bits: bit 0 is busy, bit 1 is the write-enable flag, bits 3:2 are the protect level, and bits 7:4 are zero.
- R3: Write-enable (0x06) sets the write-enable flag and write-disable (0x04) clears it. A write command (0x02) given while the flag is clear leaves the memory unchanged and starts no busy window.
- R4: Programming starts only when chip select rises after a whole number of bytes, with at least one data byte. Busy then reads 1 for WR_CYCLES clocks. If chip select rises in the middle of a byte, nothing is programmed.
- R5: While busy, every command other than status read is ignored. A write-enable has no effect, and a read drives no data.
- R6: The write-enable flag clears when the write cycle completes.
- R7: Within a page write, the low PAGE_W address bits advance after each data byte and wrap inside the page, while the upper bits stay fixed. A later byte overwrites an earlier byte at the same offset.
- R8: The serial output is enabled only while read or status data is being shifted. Data leaves MSB first and changes on falling serial clock edges, so the master samples it on rising edges, in mode 0 and in mode 3.
- R9: In read (0x03) and write (0x02) commands, bit 3 of the command byte is address bit 8 when ADDR_W is 9.
- R10: Write-status (0x01) takes its data byte only when the write-enable flag is set, and it changes only status bits 3:2.
- R11: The protect levels are: 00 covers nothing, 01 the upper quarter of the array, 10 the upper half and 11 all of it. A write that starts inside the covered region is refused: no busy window and no memory change.
- R12: A read sends bytes from consecutive addresses. The address counts across page boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, synchronous to clk |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | High while spi_so is driven |

## Verification
The assertions assume that chip select, the serial clock and the serial input change only between system clock edges. They also assume that chip select changes only while the serial clock is idle, so a busy window can start only after a transaction has closed. The stimulus meets these assumptions by holding every serial clock phase for four system clocks. It moves chip select only with the clock at its idle level for the current mode, and it drives every pin one time step after a clock edge.

// File: rtl/sek_pkg.sv
`timescale 1ns/1ps
package sek_pkg;
    localparam logic [2:0] OP_WRSR  = 3'd1;
    localparam logic [2:0] OP_WRITE = 3'd2;
    localparam logic [2:0] OP_READ  = 3'd3;
    localparam logic [2:0] OP_WRDI  = 3'd4;
    localparam logic [2:0] OP_RDSR  = 3'd5;
    localparam logic [2:0] OP_WREN  = 3'd6;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_WDATA, PH_RDATA, PH_STAT, PH_SRDATA, PH_SKIP
    } phase_t;

    function automatic logic [7:0] status_byte(input logic [1:0] lvl,
                                               input logic en,
                                               input logic bsy);
        return {4'b0000, lvl, en, bsy};
    endfunction

    // top2 holds the two most significant address bits
    function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top2);
        case (lvl)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/sek_edge.sv
`timescale 1ns/1ps
module sek_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic sel
);
    logic sck_q, cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign cs_rise  = cs_n & ~cs_q;
    assign sel      = ~cs_n;
endmodule

// File: rtl/sek_timer.sv
`timescale 1ns/1ps
module sek_timer #(
    parameter int WR_CYCLES = 1000,
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(WR_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/sek_array.sv
`timescale 1ns/1ps
module sek_array #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [7:0]                    rd_data,
    input  logic                          commit,
    input  logic [ADDR_W-PAGE_W-1:0]      page,
    input  logic [PAGE_N-1:0][7:0]        wbuf,
    input  logic [PAGE_N-1:0]             mask
);
    logic [DEPTH-1:0][7:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_N; i++)
                if (mask[i]) mem[{page, PAGE_W'(i)}] <= wbuf[i];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sek_core.sv
`timescale 1ns/1ps
module sek_core
    import sek_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sck_rise,
    input  logic                     sck_fall,
    input  logic                     cs_rise,
    input  logic                     sel,
    input  logic                     si,
    input  logic                     busy,
    input  logic                     done,
    input  logic [7:0]               rd_data,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     so,
    output logic                     so_oe,
    output logic                     wel,
    output logic [1:0]               bp,
    output logic                     wr_start,
    output logic [ADDR_W-PAGE_W-1:0] page,
    output logic [PAGE_N-1:0][7:0]   pbuf,
    output logic [PAGE_N-1:0]        pmask
);
    phase_t              phase;
    logic [2:0]          bitcnt;
    logic [6:0]          sh;
    logic [ADDR_W-1:0]   addr;
    logic [PAGE_W-1:0]   boff;
    logic                a8, is_rd;
    logic [7:0]          tx_sh;
    logic                tx_act;

    logic [7:0]          rx;
    logic [8:0]          wide_in;
    logic [ADDR_W-1:0]   addr_in;
    logic [7:0]          stat;
    logic                op_ok;

    assign rx      = {sh, si};
    assign wide_in = {a8, rx};
    assign addr_in = wide_in[ADDR_W-1:0];
    assign stat    = status_byte(bp, wel, busy);
    assign op_ok   = (rx[7:4] == 4'h0) &&
                     (!rx[3] || ((ADDR_W > 8) && (rx[2:0] == OP_READ || rx[2:0] == OP_WRITE)));
    assign rd_addr = (phase == PH_ADDR) ? addr_in : addr;
    assign page    = addr[ADDR_W-1:PAGE_W];

    assign wr_start = cs_rise && (phase == PH_WDATA) && (bitcnt == 3'd0) &&
                      (|pmask) && !prot_hit(bp, addr[ADDR_W-1 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            sh     <= '0;
            addr   <= '0;
            boff   <= '0;
            a8     <= 1'b0;
            is_rd  <= 1'b0;
            tx_sh  <= '0;
            tx_act <= 1'b0;
            so     <= 1'b0;
            so_oe  <= 1'b0;
            wel    <= 1'b0;
            bp     <= '0;
            pbuf   <= '0;
            pmask  <= '0;
        end else begin
            if (!sel) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                tx_act <= 1'b0;
                so_oe  <= 1'b0;
            end else if (sck_rise) begin
                sh     <= rx[6:0];
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == 3'd7) begin
                    case (phase)
                        PH_IDLE: begin
                            a8    <= rx[3];
                            is_rd <= (rx[2:0] == OP_READ);
                            if (!op_ok || (busy && rx[2:0] != OP_RDSR))
                                phase <= PH_SKIP;
                            else begin
                                case (rx[2:0])
                                    OP_WREN:  begin wel <= 1'b1; phase <= PH_SKIP; end
                                    OP_WRDI:  begin wel <= 1'b0; phase <= PH_SKIP; end
                                    OP_RDSR:  begin phase <= PH_STAT; tx_sh <= stat; tx_act <= 1'b1; end
                                    OP_WRSR:  phase <= wel ? PH_SRDATA : PH_SKIP;
                                    OP_READ:  phase <= PH_ADDR;
                                    OP_WRITE: phase <= wel ? PH_ADDR : PH_SKIP;
                                    default:  phase <= PH_SKIP;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            if (is_rd) begin
                                addr   <= addr_in + 1'b1;
                                tx_sh  <= rd_data;
                                tx_act <= 1'b1;
                                phase  <= PH_RDATA;
                            end else begin
                                addr  <= addr_in;
                                boff  <= addr_in[PAGE_W-1:0];
                                pmask <= '0;
                                phase <= PH_WDATA;
                            end
                        end
                        PH_WDATA: begin
                            pbuf[boff]  <= rx;
                            pmask[boff] <= 1'b1;
                            boff        <= boff + 1'b1;
                        end
                        PH_RDATA: begin
                            tx_sh <= rd_data;
                            addr  <= addr + 1'b1;
                        end
                        PH_STAT:   tx_sh <= stat;
                        PH_SRDATA: begin
                            bp    <= rx[3:2];
                            phase <= PH_SKIP;
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall && tx_act) begin
                so    <= tx_sh[7];
                tx_sh <= {tx_sh[6:0], 1'b0};
                so_oe <= 1'b1;
            end
            if (done) wel <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_eeprom_engine.sv
`timescale 1ns/1ps
module spi_eeprom_engine #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 1000,
    localparam int PAGE_N   = 1 << PAGE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe
);
    logic                     sck_rise, sck_fall, cs_rise, sel;
    logic                     busy, done, wel, wr_start;
    logic [1:0]               bp;
    logic [ADDR_W-1:0]        rd_addr;
    logic [7:0]               rd_data;
    logic [ADDR_W-PAGE_W-1:0] page;
    logic [PAGE_N-1:0][7:0]   pbuf;
    logic [PAGE_N-1:0]        pmask;

    sek_edge u_edge (
        .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise), .sel(sel)
    );

    sek_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(wr_start), .busy(busy), .done(done)
    );

    sek_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .commit(wr_start), .page(page), .wbuf(pbuf), .mask(pmask)
    );

    sek_core #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_core (
        .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .sel(sel), .si(spi_si), .busy(busy), .done(done),
        .rd_data(rd_data), .rd_addr(rd_addr), .so(spi_so), .so_oe(spi_so_oe),
        .wel(wel), .bp(bp), .wr_start(wr_start), .page(page),
        .pbuf(pbuf), .pmask(pmask)
    );
endmodule

// File: rtl/sek_checker.sv
`timescale 1ns/1ps
module sek_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       so_oe,
    input logic       busy,
    input logic       wel,
    input logic [1:0] bp,
    input logic       wr_start
);
    assert_oe_off_deselected_R8: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !so_oe);

    assert_start_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel));

    assert_wel_clear_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    assert_level_frozen_busy_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(bp));

    assert_start_makes_busy_R4: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> busy);
endmodule

bind spi_eeprom_engine sek_checker u_chk (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .so_oe(spi_so_oe),
    .busy(busy), .wel(wel), .bp(bp), .wr_start(wr_start)
);

// File: tb/spi_eeprom_engine_bench.sv
`timescale 1ns/1ps
module spi_eeprom_engine_bench;
    localparam int WRC = 600;
    localparam int H   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic so, oe;
    logic mode3 = 1'b0;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       mon_en = 1'b0;
    logic [7:0] mon_sh = '0;
    int         mon_n = 0;
    logic       mon_oe_bad = 1'b0;
    logic       finished = 1'b0;

    always #2 clk = ~clk;

    spi_eeprom_engine #(.WR_CYCLES(WRC)) u_spi_eeprom_engine (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_so(so), .spi_so_oe(oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: collects bits on master sampling edges, pops scoreboard
    always @(posedge sck) begin
        if (mon_en) begin
            logic [7:0] got, want;
            string t;
            got = {mon_sh[6:0], so};
            mon_sh = got;
            if (oe !== 1'b1) mon_oe_bad = 1'b1;
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                want = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got === want && !mon_oe_bad, t, {mon_oe_bad, got}, want);
                mon_oe_bad = 1'b0;
            end
        end
    end

    task automatic hw();
        repeat (H) @(posedge clk);
        #1;
    endtask

    task automatic begin_x();
        sck = mode3;
        hw();
        cs_n = 1'b0;
        hw();
    endtask

    task automatic end_x();
        hw();
        cs_n = 1'b1;
        hw();
        hw();
    endtask

    task automatic tx_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            if (mode3) begin
                sck = 1'b0; si = b[i]; hw(); sck = 1'b1; hw();
            end else begin
                si = b[i]; hw(); sck = 1'b1; hw(); sck = 1'b0;
            end
        end
    endtask

    task automatic tx_byte(input logic [7:0] b);
        tx_bits(b, 8);
    endtask

    task automatic rd_expect(input logic [7:0] e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        mon_en = 1'b1;
        tx_byte(8'h00);
        mon_en = 1'b0;
    endtask

    task automatic cmd1(input logic [7:0] op);
        begin_x(); tx_byte(op); end_x();
    endtask

    task automatic status_expect(input logic [7:0] e, input string req);
        begin_x(); tx_byte(8'h05); rd_expect(e, req); end_x();
    endtask

    task automatic read1(input logic [7:0] op, input logic [7:0] a,
                         input logic [7:0] e, input string req);
        begin_x(); tx_byte(op); tx_byte(a); rd_expect(e, req); end_x();
    endtask

    task automatic wait_ready();
        repeat (WRC + 40) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        hw();

        // R1 reset state
        check(oe === 1'b0, "R1 oe after reset", oe, 0);
        status_expect(8'h00, "R1/R2 status after reset");
        read1(8'h03, 8'h00, 8'hFF, "R1 erased memory");

        // R3 write without enable
        begin_x(); tx_byte(8'h02); tx_byte(8'h10); tx_byte(8'h55); end_x();
        status_expect(8'h00, "R3 no busy without enable");
        read1(8'h03, 8'h10, 8'hFF, "R3 memory untouched");

        cmd1(8'h06);
        status_expect(8'h02, "R3 enable flag set");
        cmd1(8'h04);
        status_expect(8'h00, "R3 enable flag cleared");

        // R4 R5 R6 R8 in mode 3
        mode3 = 1'b1;
        cmd1(8'h06);
        begin_x(); tx_byte(8'h02); tx_byte(8'h05); tx_byte(8'hAA); tx_byte(8'hBB); end_x();
        begin_x(); tx_byte(8'h05); rd_expect(8'h03, "R4 busy after write"); rd_expect(8'h03, "R2 repeated status"); end_x();
        cmd1(8'h06);
        begin_x(); tx_byte(8'h03); tx_byte(8'h05); tx_byte(8'h00);
        check(oe === 1'b0, "R5 read ignored while busy", oe, 0);
        end_x();
        wait_ready();
        status_expect(8'h00, "R6/R5 flag cleared after cycle");
        begin_x(); tx_byte(8'h03); tx_byte(8'h05);
        rd_expect(8'hAA, "R4/R8 first byte mode 3"); rd_expect(8'hBB, "R12 next byte");
        end_x();
        check(oe === 1'b0, "R8 oe off after deselect", oe, 0);

        // R7 page wrap in mode 0
        mode3 = 1'b0;
        cmd1(8'h06);
        begin_x(); tx_byte(8'h02); tx_byte(8'h1E);
        tx_byte(8'h11); tx_byte(8'h22); tx_byte(8'h33); tx_byte(8'h44); end_x();
        wait_ready();
        begin_x(); tx_byte(8'h03); tx_byte(8'h1E);
        rd_expect(8'h11, "R7 byte at 1E"); rd_expect(8'h22, "R7 byte at 1F");
        rd_expect(8'hFF, "R12 crosses into next page"); end_x();
        begin_x(); tx_byte(8'h03); tx_byte(8'h10);
        rd_expect(8'h33, "R7 wrapped to page start"); rd_expect(8'h44, "R7 wrapped second"); end_x();

        // R7 overwrite within buffer
        cmd1(8'h06);
        begin_x(); tx_byte(8'h02); tx_byte(8'h40);
        for (int k = 0; k < 18; k++) tx_byte(8'(k));
        end_x();
        wait_ready();
        begin_x(); tx_byte(8'h03); tx_byte(8'h40);
        rd_expect(8'h10, "R7 overwrite offset 0"); rd_expect(8'h11, "R7 overwrite offset 1");
        rd_expect(8'h02, "R7 untouched offset 2"); end_x();

        // R9 ninth address bit
        cmd1(8'h06);
        begin_x(); tx_byte(8'h0A); tx_byte(8'h07); tx_byte(8'h5A); end_x();
        wait_ready();
        read1(8'h0B, 8'h07, 8'h5A, "R9 upper half byte");
        read1(8'h03, 8'h07, 8'hFF, "R9 lower half untouched");

        // R4 partial byte aborts
        cmd1(8'h06);
        begin_x(); tx_byte(8'h02); tx_byte(8'h60); tx_byte(8'hC3); tx_bits(8'hE0, 3); end_x();
        status_expect(8'h02, "R4 aborted write not busy");
        read1(8'h03, 8'h60, 8'hFF, "R4 aborted write no change");

        // R10 status write
        cmd1(8'h04);
        begin_x(); tx_byte(8'h01); tx_byte(8'h0C); end_x();
        status_expect(8'h00, "R10 ignored without enable");
        cmd1(8'h06);
        begin_x(); tx_byte(8'h01); tx_byte(8'hF7); end_x();
        status_expect(8'h06, "R10 only bits 3:2 written");

        // R11 protection, level 01 covers 0x180..0x1FF
        begin_x(); tx_byte(8'h0A); tx_byte(8'h80); tx_byte(8'h99); end_x();
        status_expect(8'h06, "R11 refused write not busy");
        read1(8'h0B, 8'h80, 8'hFF, "R11 protected byte unchanged");
        mode3 = 1'b1;
        begin_x(); tx_byte(8'h0A); tx_byte(8'h7F); tx_byte(8'h77); end_x();
        status_expect(8'h07, "R11 write below region busy");
        wait_ready();
        read1(8'h0B, 8'h7F, 8'h77, "R11 write below region stored");

        // R11 level 10 covers 0x100..0x1FF
        cmd1(8'h06);
        begin_x(); tx_byte(8'h01); tx_byte(8'h08); end_x();
        begin_x(); tx_byte(8'h0A); tx_byte(8'h20); tx_byte(8'h31); end_x();
        status_expect(8'h0A, "R11 upper half refused");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule